// File: doc/BRIEF.md
# I2C Target Address Filter with Bus Reset Command

This block sits between a bit-level I2C receiver and the register path of an I2C target. The receiver hands it one-cycle events: a start (or repeated start), a stop, and each received byte with its value. For every byte the block returns an acknowledge decision one clock later. For the first byte after a start it decides whether the target answers: to its fixed device address, to a programmable broadcast (all-call) address, or to one of three programmable group (sub-call) addresses. Each of the programmable addresses has its own enable. The block then reports which kind of address matched, so that the register path knows whether to accept the bytes that follow.

The block also recognises a bus-wide reset command. This is a write to the reserved address 1001111 (byte 9Eh), followed by the key bytes A5h and then 5Ah. Each key byte is acknowledged only when it is correct. The command commits only at the stop that follows, where the block emits a one-cycle reset request. The same request returns the block's own address registers and enables to their power-up values.

The address registers and the enable flags live inside the block. A narrow write port from the register path updates them.

Top module: `i2c_addr_filter`

## Requirements
- R1: After rst_n is released: dec_valid, dec_ack, match_kind and soft_reset are all 0. The broadcast address is 90h and enabled. The group addresses are 92h, 94h and 98h, and all three are disabled.
- R2: A byte_valid pulse without start or stop in the same cycle produces dec_valid for exactly the next cycle, and dec_ack is only ever 1 together with dec_valid. A byte received while no transfer is open (before any start, or after a stop) is not acknowledged.
- R3: The first byte after a start is the address byte. If bits 7:1 equal dev_addr, it is acknowledged for both directions, match_kind becomes 1 and match_rd copies bit 0. The match_kind codes are: 0 none, 1 device, 2 broadcast, 3/4/5 group 1/2/3, 6 reset command.
- R4: While the broadcast enable is set, the broadcast address is acknowledged with match_kind 2, for both write (90h) and read (91h). While the enable is clear, that address gets no acknowledge. The enable is flag bit 0, written with cfg_sel 0.
- R5: Group address n (n = 1..3) is acknowledged with match_kind 2+n, for both directions, only while its enable (flag bit n, cfg_sel 0) is set.
- R6: cfg_sel 1 writes the broadcast address, and cfg_sel 2, 3 and 4 write group addresses 1, 2 and 3. Only bits 7:1 of the written value are kept and compared; bit 0 of a written value has no effect.
- R7: When one address byte matches several kinds, the reported kind is chosen in the order device, broadcast, group 1, group 2, group 3.
- R8: Byte 9Eh as an address is acknowledged with match_kind 6. Byte 9Fh (read) is not acknowledged and gives match_kind 0. Neither byte ever matches the device, broadcast or a group address, even when one of them is programmed to that value.
- R9: After the 9Eh address, the first data byte is acknowledged only if it is A5h. The second is acknowledged only if the first was A5h and it is 5Ah. Every other byte of that transfer, including any third byte, is not acknowledged.
- R10: soft_reset pulses for exactly one cycle, in the cycle after a stop, only when the transfer was 9Eh, A5h, 5Ah and nothing else. Any other sequence produces no pulse.
- R11: A repeated start or a stop in the middle of the reset command abandons it. Later key bytes do not complete it.
- R12: In the cycle after the soft_reset pulse, the broadcast and group addresses and all four enables hold their R1 values again. dev_addr is unaffected.
- R13: Data bytes after a matched write address are acknowledged. Data bytes after a read address, or after an address that did not match, are not.
- R14: A start or a stop sets match_kind to 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_addr | input | 7 | Fixed 7-bit device address |
| evt_start | input | 1 | Start or repeated start seen (one-cycle pulse) |
| evt_stop | input | 1 | Stop seen (one-cycle pulse) |
| byte_valid | input | 1 | A received byte is presented on byte_data |
| byte_data | input | 8 | Received byte value |
| cfg_wr | input | 1 | Write strobe for the address/enable store |
| cfg_sel | input | 3 | 0 flags, 1 broadcast, 2..4 group 1..3 |
| cfg_wdata | input | 8 | Write value for the store |
| dec_valid | output | 1 | Acknowledge decision available |
| dec_ack | output | 1 | 1 = acknowledge, 0 = no acknowledge |
| match_kind | output | 3 | Kind of address matched in this transfer |
| match_rd | output | 1 | Direction bit of the matched address byte |
| soft_reset | output | 1 | One-cycle reset request after a valid reset command |

## Verification
The address decision is exercised with the device address in both directions, and with the broadcast address with its enable set and then cleared. This separates a real compare from a mere enable check. Group addresses are probed at their defaults while disabled and again after enabling, so that an enable wired to the wrong address would show. Addresses written with bit 0 set, and addresses programmed to collide with one another or with 9Eh, check the masking, the priority order and the reservation of the reset command. The reset command is driven with wrong first and second keys, an extra third byte, an abort by repeated start and by early stop, and finally the correct form. Only the correct form may pulse soft_reset, and afterwards every programmable address must be back at its power-up value.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;

  localparam int NUM_SUB = 3;

  typedef enum logic [2:0] {
    MK_NONE = 3'd0,
    MK_DEV  = 3'd1,
    MK_ALL  = 3'd2,
    MK_SUB1 = 3'd3,
    MK_SUB2 = 3'd4,
    MK_SUB3 = 3'd5,
    MK_RST  = 3'd6
  } match_kind_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2
  } phase_e;

  typedef enum logic [2:0] {
    RS_IDLE  = 3'd0,
    RS_ARMED = 3'd1,
    RS_KEY1  = 3'd2,
    RS_KEY2  = 3'd3,
    RS_DEAD  = 3'd4
  } rst_seq_e;

  // 7-bit compare of a stored address against the upper bits of a byte
  function automatic logic addr_hit(input logic [6:0] stored, input logic [6:0] got);
    return stored == got;
  endfunction

  // kind code of group address number idx (0-based)
  function automatic match_kind_e sub_kind(input int idx);
    match_kind_e k;
    case (idx)
      0:       k = MK_SUB1;
      1:       k = MK_SUB2;
      default: k = MK_SUB3;
    endcase
    return k;
  endfunction

endpackage

// File: rtl/i2c_am_cfg.sv
module i2c_am_cfg
  import i2c_am_pkg::*;
#(
  parameter logic [7:0]           ALLCALL_DEF = 8'h90,
  parameter logic [NUM_SUB*8-1:0] SUB_DEF     = {8'h98, 8'h94, 8'h92},
  parameter int                   SEL_W       = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    soft_clr,
  input  logic                    wr,
  input  logic [SEL_W-1:0]        sel,
  input  logic [7:0]              wdata,
  output logic [6:0]              allcall_addr,
  output logic                    allcall_en,
  output logic [NUM_SUB-1:0][6:0] sub_addr,
  output logic [NUM_SUB-1:0]      sub_en
);

  localparam logic [SEL_W-1:0] SEL_FLAGS = SEL_W'(0);
  localparam logic [SEL_W-1:0] SEL_ALL   = SEL_W'(1);
  localparam int               SEL_SUB0  = 2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      allcall_en <= 1'b1;
      sub_en     <= '0;
    end else if (soft_clr) begin
      allcall_en <= 1'b1;
      sub_en     <= '0;
    end else if (wr && sel == SEL_FLAGS) begin
      allcall_en <= wdata[0];
      sub_en     <= wdata[NUM_SUB:1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      allcall_addr <= ALLCALL_DEF[7:1];
    end else if (soft_clr) begin
      allcall_addr <= ALLCALL_DEF[7:1];
    end else if (wr && sel == SEL_ALL) begin
      allcall_addr <= wdata[7:1];
    end
  end

  for (genvar g = 0; g < NUM_SUB; g++) begin : g_sub
    localparam logic [6:0]       DEF7   = SUB_DEF[g*8+1 +: 7];
    localparam logic [SEL_W-1:0] MY_SEL = SEL_W'(SEL_SUB0 + g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sub_addr[g] <= DEF7;
      end else if (soft_clr) begin
        sub_addr[g] <= DEF7;
      end else if (wr && sel == MY_SEL) begin
        sub_addr[g] <= wdata[7:1];
      end
    end
  end

endmodule

// File: rtl/i2c_am_match.sv
module i2c_am_match
  import i2c_am_pkg::*;
#(
  parameter logic [6:0] RST_ADDR = 7'h4F
) (
  input  logic [6:0]              addr7,
  input  logic [6:0]              dev_addr,
  input  logic [6:0]              allcall_addr,
  input  logic                    allcall_en,
  input  logic [NUM_SUB-1:0][6:0] sub_addr,
  input  logic [NUM_SUB-1:0]      sub_en,
  output match_kind_e             kind
);

  logic [NUM_SUB-1:0] sub_hit;
  logic               dev_hit;
  logic               all_hit;
  logic               rst_hit;

  for (genvar g = 0; g < NUM_SUB; g++) begin : g_hit
    assign sub_hit[g] = sub_en[g] && addr_hit(sub_addr[g], addr7);
  end

  assign dev_hit = addr_hit(dev_addr, addr7);
  assign all_hit = allcall_en && addr_hit(allcall_addr, addr7);
  assign rst_hit = addr_hit(RST_ADDR, addr7);

  // lowest priority first, each later test overrides
  always_comb begin
    kind = MK_NONE;
    for (int i = NUM_SUB - 1; i >= 0; i--) begin
      if (sub_hit[i]) kind = sub_kind(i);
    end
    if (all_hit) kind = MK_ALL;
    if (dev_hit) kind = MK_DEV;
    if (rst_hit) kind = MK_RST;
  end

endmodule

// File: rtl/i2c_am_rstseq.sv
module i2c_am_rstseq
  import i2c_am_pkg::*;
#(
  parameter logic [6:0] RST_ADDR = 7'h4F,
  parameter logic [7:0] KEY1     = 8'hA5,
  parameter logic [7:0] KEY2     = 8'h5A
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       stop,
  input  logic       byte_go,
  input  logic       addr_byte,
  input  logic [7:0] byte_data,
  output logic       seq_ack,
  output logic       commit
);

  rst_seq_e state_q, state_d;
  logic     commit_d;

  always_comb begin
    state_d  = state_q;
    seq_ack  = 1'b0;
    commit_d = 1'b0;
    if (start) begin
      state_d = RS_IDLE;
    end else if (stop) begin
      state_d  = RS_IDLE;
      commit_d = (state_q == RS_KEY2);
    end else if (byte_go) begin
      if (addr_byte) begin
        seq_ack = (byte_data == {RST_ADDR, 1'b0});
        state_d = seq_ack ? RS_ARMED : RS_IDLE;
      end else begin
        case (state_q)
          RS_ARMED: begin
            seq_ack = (byte_data == KEY1);
            state_d = seq_ack ? RS_KEY1 : RS_DEAD;
          end
          RS_KEY1: begin
            seq_ack = (byte_data == KEY2);
            state_d = seq_ack ? RS_KEY2 : RS_DEAD;
          end
          RS_KEY2:  state_d = RS_DEAD;
          RS_DEAD:  state_d = RS_DEAD;
          default:  state_d = RS_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RS_IDLE;
      commit  <= 1'b0;
    end else begin
      state_q <= state_d;
      commit  <= commit_d;
    end
  end

endmodule

// File: rtl/i2c_addr_filter.sv
module i2c_addr_filter
  import i2c_am_pkg::*;
#(
  parameter logic [7:0]           ALLCALL_DEF = 8'h90,
  parameter logic [NUM_SUB*8-1:0] SUB_DEF     = {8'h98, 8'h94, 8'h92},
  parameter logic [6:0]           RST_ADDR    = 7'h4F,
  parameter logic [7:0]           KEY1        = 8'hA5,
  parameter logic [7:0]           KEY2        = 8'h5A,
  parameter int                   SEL_W       = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [6:0]       dev_addr,
  input  logic             evt_start,
  input  logic             evt_stop,
  input  logic             byte_valid,
  input  logic [7:0]       byte_data,
  input  logic             cfg_wr,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic [7:0]       cfg_wdata,
  output logic             dec_valid,
  output logic             dec_ack,
  output logic [2:0]       match_kind,
  output logic             match_rd,
  output logic             soft_reset
);

  logic [6:0]              allcall_addr;
  logic                    allcall_en;
  logic [NUM_SUB-1:0][6:0] sub_addr;
  logic [NUM_SUB-1:0]      sub_en;
  match_kind_e             hit_kind;
  match_kind_e             kind_q, kind_d;
  phase_e                  ph_q;
  logic                    rd_q;
  logic                    byte_go;
  logic                    addr_phase;
  logic                    seq_ack;
  logic                    ack_d;

  // named events shared with the checker
  assign byte_go    = byte_valid && !evt_start && !evt_stop;
  assign addr_phase = byte_go && (ph_q == PH_ADDR);

  i2c_am_cfg #(
    .ALLCALL_DEF (ALLCALL_DEF),
    .SUB_DEF     (SUB_DEF),
    .SEL_W       (SEL_W)
  ) cfg_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .soft_clr     (soft_reset),
    .wr           (cfg_wr),
    .sel          (cfg_sel),
    .wdata        (cfg_wdata),
    .allcall_addr (allcall_addr),
    .allcall_en   (allcall_en),
    .sub_addr     (sub_addr),
    .sub_en       (sub_en)
  );

  i2c_am_match #(
    .RST_ADDR (RST_ADDR)
  ) match_i (
    .addr7        (byte_data[7:1]),
    .dev_addr     (dev_addr),
    .allcall_addr (allcall_addr),
    .allcall_en   (allcall_en),
    .sub_addr     (sub_addr),
    .sub_en       (sub_en),
    .kind         (hit_kind)
  );

  i2c_am_rstseq #(
    .RST_ADDR (RST_ADDR),
    .KEY1     (KEY1),
    .KEY2     (KEY2)
  ) seq_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (evt_start),
    .stop      (evt_stop),
    .byte_go   (byte_go),
    .addr_byte (addr_phase),
    .byte_data (byte_data),
    .seq_ack   (seq_ack),
    .commit    (soft_reset)
  );

  always_comb begin
    kind_d = (hit_kind == MK_RST && byte_data[0]) ? MK_NONE : hit_kind;
    ack_d  = 1'b0;
    if (addr_phase) begin
      ack_d = (hit_kind == MK_RST) ? seq_ack : (hit_kind != MK_NONE);
    end else if (ph_q == PH_DATA) begin
      ack_d = (kind_q == MK_RST) ? seq_ack : (kind_q != MK_NONE && !rd_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      kind_q <= MK_NONE;
      rd_q   <= 1'b0;
    end else if (evt_start) begin
      ph_q   <= PH_ADDR;
      kind_q <= MK_NONE;
      rd_q   <= 1'b0;
    end else if (evt_stop) begin
      ph_q   <= PH_IDLE;
      kind_q <= MK_NONE;
      rd_q   <= 1'b0;
    end else if (addr_phase) begin
      ph_q   <= PH_DATA;
      kind_q <= kind_d;
      rd_q   <= byte_data[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid <= 1'b0;
      dec_ack   <= 1'b0;
    end else begin
      dec_valid <= byte_go;
      dec_ack   <= byte_go && ack_d;
    end
  end

  assign match_kind = kind_q;
  assign match_rd   = rd_q;

endmodule

// File: rtl/i2c_addr_filter_chk.sv
module i2c_addr_filter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       evt_start,
  input logic       evt_stop,
  input logic       byte_valid,
  input logic [7:0] byte_data,
  input logic       addr_phase,
  input logic       byte_go,
  input logic       dec_valid,
  input logic       dec_ack,
  input logic [2:0] match_kind,
  input logic       soft_reset
);

  // R2: every plain byte gets a decision in the next cycle
  a_r2_dec_follows_byte: assert property (@(posedge clk) disable iff (!rst_n)
    byte_go |=> dec_valid);

  // R2: no decision without a byte
  a_r2_no_spurious_dec: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_valid |=> !dec_valid);

  // R2: acknowledge only with a decision
  a_r2_ack_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    dec_ack |-> dec_valid);

  // R8: reset address with read direction never acknowledged
  a_r8_read_reset_nack: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_phase && byte_data == 8'h9F) |=> !dec_ack);

  // R10: reset request only right after a stop
  a_r10_reset_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    soft_reset |-> $past(evt_stop));

  // R10: reset request is a single-cycle pulse
  a_r10_reset_single: assert property (@(posedge clk) disable iff (!rst_n)
    soft_reset |=> !soft_reset);

  // R14: start and stop clear the match kind
  a_r14_start_stop_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_start || evt_stop) |=> (match_kind == 3'd0));

endmodule

bind i2c_addr_filter i2c_addr_filter_chk chk_i (.*);

// File: tb/i2c_addr_filter_tb.sv
module i2c_addr_filter_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] dev_addr = 7'h20;
  logic       evt_start = 1'b0;
  logic       evt_stop = 1'b0;
  logic       byte_valid = 1'b0;
  logic [7:0] byte_data = 8'h00;
  logic       cfg_wr = 1'b0;
  logic [2:0] cfg_sel = 3'd0;
  logic [7:0] cfg_wdata = 8'h00;
  logic       dec_valid, dec_ack, match_rd, soft_reset;
  logic [2:0] match_kind;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  i2c_addr_filter dut_i (
    .clk(clk), .rst_n(rst_n), .dev_addr(dev_addr),
    .evt_start(evt_start), .evt_stop(evt_stop),
    .byte_valid(byte_valid), .byte_data(byte_data),
    .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .dec_valid(dec_valid), .dec_ack(dec_ack), .match_kind(match_kind),
    .match_rd(match_rd), .soft_reset(soft_reset)
  );

  task automatic check_eq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_start();
    @(negedge clk); evt_start = 1'b1;
    @(negedge clk); evt_start = 1'b0;
    check_eq("R14 start clears kind", match_kind, 0);
  endtask

  task automatic do_stop(input string tag, input logic exp_sr);
    @(negedge clk); evt_stop = 1'b1;
    @(negedge clk); evt_stop = 1'b0;
    check_eq({tag, " soft_reset"}, soft_reset, exp_sr);
    check_eq("R14 stop clears kind", match_kind, 0);
    @(negedge clk);
    check_eq("R10 pulse width", soft_reset, 0);
  endtask

  // send one byte, check decision and kind
  task automatic send(input string tag, input logic [7:0] b, input logic exp_ack,
                      input int exp_kind);
    @(negedge clk); byte_valid = 1'b1; byte_data = b;
    @(negedge clk); byte_valid = 1'b0;
    check_eq("R2 dec_valid", dec_valid, 1);
    check_eq({tag, " ack"}, dec_ack, exp_ack);
    check_eq({tag, " kind"}, match_kind, exp_kind);
  endtask

  task automatic cfg(input logic [2:0] s, input logic [7:0] d);
    @(negedge clk); cfg_wr = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic t_reset();
    check_eq("R1 dec_valid", dec_valid, 0);
    check_eq("R1 dec_ack", dec_ack, 0);
    check_eq("R1 kind", match_kind, 0);
    check_eq("R1 soft_reset", soft_reset, 0);
    send("R2 byte outside transfer", 8'h40, 1'b0, 0);
  endtask

  task automatic t_device();
    do_start();
    send("R3 device write", 8'h40, 1'b1, 1);
    check_eq("R3 rd bit", match_rd, 0);
    send("R13 data after write", 8'h12, 1'b1, 1);
    do_start();
    send("R3 device read", 8'h41, 1'b1, 1);
    check_eq("R3 rd bit", match_rd, 1);
    send("R13 data after read", 8'h34, 1'b0, 1);
    do_stop("R10 plain stop", 1'b0);
    send("R2 byte after stop", 8'h40, 1'b0, 0);
  endtask

  task automatic t_allcall();
    do_start();
    send("R1 R4 broadcast default write", 8'h90, 1'b1, 2);
    do_start();
    send("R4 broadcast read", 8'h91, 1'b1, 2);
    do_stop("R10 plain stop", 1'b0);
    cfg(3'd0, 8'h00);
    do_start();
    send("R4 broadcast disabled", 8'h90, 1'b0, 0);
    send("R13 data after no match", 8'h55, 1'b0, 0);
    do_stop("R10 plain stop", 1'b0);
  endtask

  task automatic t_sub();
    do_start();
    send("R1 R5 group1 disabled default", 8'h92, 1'b0, 0);
    do_stop("R10 plain stop", 1'b0);
    cfg(3'd0, 8'h03);
    do_start();
    send("R5 group1 write", 8'h92, 1'b1, 3);
    do_start();
    send("R5 group1 read", 8'h93, 1'b1, 3);
    do_start();
    send("R5 group2 still disabled", 8'h94, 1'b0, 0);
    do_start();
    send("R5 group3 still disabled", 8'h98, 1'b0, 0);
    do_stop("R10 plain stop", 1'b0);
    cfg(3'd0, 8'h0F);
    do_start();
    send("R5 group2 enabled", 8'h94, 1'b1, 4);
    do_start();
    send("R5 group3 enabled", 8'h99, 1'b1, 5);
    do_stop("R10 plain stop", 1'b0);
  endtask

  task automatic t_mask();
    cfg(3'd3, 8'hA7);
    do_start();
    send("R6 group2 bit0 ignored write", 8'hA6, 1'b1, 4);
    do_start();
    send("R6 group2 bit0 ignored read", 8'hA7, 1'b1, 4);
    do_start();
    send("R6 old group2 gone", 8'h94, 1'b0, 0);
    do_stop("R10 plain stop", 1'b0);
  endtask

  task automatic t_prio();
    cfg(3'd1, 8'h40);
    do_start();
    send("R7 device over broadcast", 8'h40, 1'b1, 1);
    do_stop("R10 plain stop", 1'b0);
    cfg(3'd2, 8'hA6);
    do_start();
    send("R7 group1 over group2", 8'hA6, 1'b1, 3);
    do_stop("R10 plain stop", 1'b0);
  endtask

  task automatic t_rst_addr();
    cfg(3'd4, 8'h9E);
    do_start();
    send("R8 reset address write", 8'h9E, 1'b1, 6);
    do_start();
    send("R8 reset address read", 8'h9F, 1'b0, 0);
    do_stop("R10 after read reset address", 1'b0);
  endtask

  task automatic t_bad_keys();
    do_start();
    send("R8 reset address", 8'h9E, 1'b1, 6);
    send("R9 wrong first key", 8'h00, 1'b0, 6);
    do_stop("R10 wrong first key", 1'b0);
    do_start();
    send("R8 reset address", 8'h9E, 1'b1, 6);
    send("R9 first key", 8'hA5, 1'b1, 6);
    send("R9 wrong second key", 8'hA5, 1'b0, 6);
    do_stop("R10 wrong second key", 1'b0);
    do_start();
    send("R8 reset address", 8'h9E, 1'b1, 6);
    send("R9 second key before first", 8'h5A, 1'b0, 6);
    send("R9 first key too late", 8'hA5, 1'b0, 6);
    do_stop("R10 swapped keys", 1'b0);
    do_start();
    send("R8 reset address", 8'h9E, 1'b1, 6);
    send("R9 first key", 8'hA5, 1'b1, 6);
    send("R9 second key", 8'h5A, 1'b1, 6);
    send("R9 third byte", 8'h77, 1'b0, 6);
    do_stop("R10 extra byte", 1'b0);
    do_start();
    send("R10 config kept after bad command", 8'hA6, 1'b1, 3);
    do_stop("R10 plain stop", 1'b0);
  endtask

  task automatic t_abort();
    do_start();
    send("R8 reset address", 8'h9E, 1'b1, 6);
    send("R9 first key", 8'hA5, 1'b1, 6);
    do_start();
    send("R11 device after repeated start", 8'h40, 1'b1, 1);
    send("R11 key byte is plain data", 8'h5A, 1'b1, 1);
    do_stop("R11 repeated start abort", 1'b0);
    do_start();
    send("R8 reset address", 8'h9E, 1'b1, 6);
    send("R9 first key", 8'hA5, 1'b1, 6);
    do_stop("R11 early stop", 1'b0);
    send("R11 key after stop", 8'h5A, 1'b0, 0);
    do_start();
    do_stop("R11 no late commit", 1'b0);
  endtask

  task automatic t_good_reset();
    do_start();
    send("R8 reset address", 8'h9E, 1'b1, 6);
    send("R9 first key", 8'hA5, 1'b1, 6);
    send("R9 second key", 8'h5A, 1'b1, 6);
    do_stop("R10 valid command", 1'b1);
    do_start();
    send("R12 device unaffected", 8'h40, 1'b1, 1);
    do_start();
    send("R12 group1 restored disabled", 8'hA6, 1'b0, 0);
    do_start();
    send("R12 broadcast restored", 8'h90, 1'b1, 2);
    do_start();
    send("R12 default group1 disabled", 8'h92, 1'b0, 0);
    do_stop("R10 plain stop", 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_device();
    t_allcall();
    t_sub();
    t_mask();
    t_prio();
    t_rst_addr();
    t_bad_keys();
    t_abort();
    t_good_reset();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule